// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block watches the stream of access events presented to a static RAM and picks out a six-step run of read addresses that encodes a nonvolatile command. The command travels inside ordinary read cycles, so no extra pins are needed. The first five reads form a fixed prefix. The sixth read chooses the command: one address asks for a STORE, which copies the volatile array into nonvolatile cells, and another asks for a RECALL, which copies it back. A third sixth-step address is reserved for factory test. It is flagged on its own output and must never start either command.

Each access event is a single-cycle pulse on `acc_valid`. The pulse carries an address and a write flag, and one pulse corresponds to one chip-enable low pulse. Any write, or any read that does not match the next expected step, ends the match. A read of the first prefix address always counts as step one, so a fresh attempt can begin immediately. While the downstream nonvolatile engine reports `busy`, the detector ignores the event stream. Requests leave as registered one-cycle pulses.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: The five prefix addresses are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F. They must be read in exactly that order, and a prefix read out of order produces no request.
- R2: After the full prefix, a read of 0x0FC0 raises `store_req` for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the event.
- R3: After the full prefix, a read of 0x0C63 raises `recall_req` for one cycle, with the same timing as R2.
- R4: After the full prefix, a read of 0x339C raises `test_hit` for one cycle and raises neither `store_req` nor `recall_req`.
- R5: An event with `acc_write`=1 at any step, whatever its address, discards all progress and produces no request.
- R6: A read whose address is not the next expected step discards progress. This includes a repeated read of the step just matched, for example 0x31C7 read twice.
- R7: After progress is discarded, the aborting read counts as step one if its address is 0x0E38, so the next expected address is 0x31C7. Any other aborting read leaves the detector idle.
- R8: While `busy`=1, all events are ignored and any progress already made is cleared.
- R9: Address bit 14 takes no part in any comparison. Only bits 13..0 are matched.
- R10: A synchronous active-high `rst` clears progress and drives all three outputs low.
- R11: At most one of the three outputs is high in any cycle, and none stays high for two cycles in a row.
- R12: A sixth read that is none of the three final addresses produces no pulse. Detection works normally afterwards.
- R13: After a command is detected the detector is idle, so repeating only the final address produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busy | input | 1 | Nonvolatile cycle in progress; events are ignored |
| acc_valid | input | 1 | One-cycle pulse per access event |
| acc_addr | input | 15 | Address of the access event |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| store_req | output | 1 | One-cycle STORE request |
| recall_req | output | 1 | One-cycle RECALL request |
| test_hit | output | 1 | One-cycle flag for the reserved test sequence |

## Verification
The assertions assume that `acc_valid` is a clean single-cycle pulse per chip-enable low pulse. They also assume that address and write flag are stable in the cycle the pulse is sampled. The stimulus meets these assumptions by driving each event for exactly one cycle, followed by at least one idle cycle. `busy` is toggled only between events or together with one. The assertions further assume that any output pulse can be traced to the event one cycle earlier. For that reason the bench never drives `busy` high in the same cycle in which it expects a request.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
  localparam int CMP_W = 14;
  localparam int NPRE  = 5;
  localparam int STEPS = NPRE + 1;
  localparam int STEP_W = $clog2(STEPS);

  localparam logic [CMP_W-1:0] KEY_STORE  = 14'h0FC0;
  localparam logic [CMP_W-1:0] KEY_RECALL = 14'h0C63;
  localparam logic [CMP_W-1:0] KEY_TEST   = 14'h339C;

  typedef logic [STEP_W-1:0] step_t;

  function automatic logic [CMP_W-1:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 14'h0E38;
      1:       prefix_key = 14'h31C7;
      2:       prefix_key = 14'h03E0;
      3:       prefix_key = 14'h3C1F;
      default: prefix_key = 14'h303F;
    endcase
  endfunction
endpackage

// File: rtl/nvcmd_addr_match.sv
module nvcmd_addr_match
  import nvcmd_pkg::*;
(
  input  logic [CMP_W-1:0] addr,
  output logic [NPRE-1:0]  pre_hit,
  output logic             fin_store,
  output logic             fin_recall,
  output logic             fin_test
);
  // one comparator per prefix key
  for (genvar g = 0; g < NPRE; g++) begin : g_pre
    assign pre_hit[g] = (addr == prefix_key(g));
  end

  assign fin_store  = (addr == KEY_STORE);
  assign fin_recall = (addr == KEY_RECALL);
  assign fin_test   = (addr == KEY_TEST);
endmodule

// File: rtl/nvcmd_seq_fsm.sv
module nvcmd_seq_fsm
  import nvcmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  logic            ev_valid,
  input  logic            ev_write,
  input  logic [NPRE-1:0] pre_hit,
  input  logic            fin_store,
  input  logic            fin_recall,
  input  logic            fin_test,
  output logic            store_q,
  output logic            recall_q,
  output logic            test_q
);
  localparam step_t LAST = step_t'(NPRE);

  step_t step_r, step_n;
  logic  step_hit;
  logic  fire_s, fire_r, fire_t;

  // does the current event match the address expected at this step
  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < NPRE; i++) begin
      if (step_r == step_t'(i)) step_hit = pre_hit[i];
    end
  end

  always_comb begin
    step_n = step_r;
    fire_s = 1'b0;
    fire_r = 1'b0;
    fire_t = 1'b0;
    if (busy) begin
      step_n = '0;
    end else if (ev_valid) begin
      if (ev_write) begin
        step_n = '0;
      end else if (step_r == LAST) begin
        fire_s = fin_store;
        fire_r = fin_recall;
        fire_t = fin_test;
        if (fin_store || fin_recall || fin_test) step_n = '0;
        else step_n = pre_hit[0] ? step_t'(1) : '0;
      end else if (step_hit) begin
        step_n = step_r + step_t'(1);
      end else begin
        step_n = pre_hit[0] ? step_t'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_r   <= '0;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
      test_q   <= 1'b0;
    end else begin
      step_r   <= step_n;
      store_q  <= fire_s;
      recall_q <= fire_r;
      test_q   <= fire_t;
    end
  end
endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
  import nvcmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              store_req,
  output logic              recall_req,
  output logic              test_hit
);
  logic [NPRE-1:0] pre_hit;
  logic            fin_store, fin_recall, fin_test;

  nvcmd_addr_match u_match (
    .addr       (acc_addr[CMP_W-1:0]),
    .pre_hit    (pre_hit),
    .fin_store  (fin_store),
    .fin_recall (fin_recall),
    .fin_test   (fin_test)
  );

  nvcmd_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .ev_valid   (acc_valid),
    .ev_write   (acc_write),
    .pre_hit    (pre_hit),
    .fin_store  (fin_store),
    .fin_recall (fin_recall),
    .fin_test   (fin_test),
    .store_q    (store_req),
    .recall_q   (recall_req),
    .test_q     (test_hit)
  );
endmodule

// File: rtl/nvcmd_seq_detect_chk.sv
module nvcmd_seq_detect_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic              store_req,
  input logic              recall_req,
  input logic              test_hit
);
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(14'h3FFF);
  logic any_out;
  assign any_out = store_req | recall_req | test_hit;

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_req, recall_req, test_hit})); // R11
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    any_out |=> !any_out); // R11
  AST_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    any_out |-> ($past(acc_valid) && !$past(rst))); // R2
  AST_NO_WRITE_CMD: assert property (@(posedge clk) disable iff (rst)
    any_out |-> !$past(acc_write)); // R5
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    any_out |-> !$past(busy)); // R8
  AST_STORE_ADDR: assert property (@(posedge clk) disable iff (rst)
    store_req |-> (($past(acc_addr) & MASK) == ADDR_W'(14'h0FC0))); // R2
  AST_RECALL_ADDR: assert property (@(posedge clk) disable iff (rst)
    recall_req |-> (($past(acc_addr) & MASK) == ADDR_W'(14'h0C63))); // R3
  AST_TEST_ADDR: assert property (@(posedge clk) disable iff (rst)
    test_hit |-> (($past(acc_addr) & MASK) == ADDR_W'(14'h339C))); // R4
endmodule

bind nvcmd_seq_detect nvcmd_seq_detect_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .acc_valid  (acc_valid),
  .acc_addr   (acc_addr),
  .acc_write  (acc_write),
  .store_req  (store_req),
  .recall_req (recall_req),
  .test_hit   (test_hit)
);

// File: tb/nvcmd_seq_detect_test.sv
module nvcmd_seq_detect_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busy = 1'b0;
  logic        acc_valid = 1'b0;
  logic [14:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        store_req, recall_req, test_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] got;  // {store, recall, test} seen after the last event

  always #4 clk = ~clk;

  nvcmd_seq_detect uut (
    .clk(clk), .rst(rst), .busy(busy), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write),
    .store_req(store_req), .recall_req(recall_req), .test_hit(test_hit)
  );

  localparam logic [14:0] P0 = 15'h0E38, P1 = 15'h31C7, P2 = 15'h03E0,
                          P3 = 15'h3C1F, P4 = 15'h303F;
  localparam logic [14:0] FS = 15'h0FC0, FR = 15'h0C63, FT = 15'h339C;

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b", req, act, exp);
    end
  endtask

  // one event, one cycle; outputs sampled at the following negedge
  task automatic send(input logic [14:0] a, input logic wr);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    got = {store_req, recall_req, test_hit};
  endtask

  task automatic rd(input logic [14:0] a);
    send(a, 1'b0);
  endtask

  task automatic prefix();
    rd(P0); rd(P1); rd(P2); rd(P3); rd(P4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset outputs", {store_req, recall_req, test_hit}, 3'b000);
    prefix();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(FS);
    chk("R10 reset clears progress", got, 3'b000);
  endtask

  task automatic t_store();
    prefix(); rd(FS);
    chk("R2 store pulse", got, 3'b100);
    @(negedge clk);
    chk("R11 pulse one cycle", {store_req, recall_req, test_hit}, 3'b000);
    rd(FS);
    chk("R13 idle after command", got, 3'b000);
  endtask

  task automatic t_recall();
    prefix(); rd(FR);
    chk("R3 recall pulse", got, 3'b010);
  endtask

  task automatic t_test();
    prefix(); rd(FT);
    chk("R4 test flag only", got, 3'b001);
  endtask

  task automatic t_order();
    rd(P1); rd(P0); rd(P2); rd(P3); rd(P4); rd(FS);
    chk("R1 wrong order", got, 3'b000);
  endtask

  task automatic t_write();
    rd(P0); rd(P1); send(P2, 1'b1); rd(P3); rd(P4); rd(FS);
    chk("R5 write mid sequence", got, 3'b000);
    prefix(); send(FS, 1'b1);
    chk("R5 write as final step", got, 3'b000);
  endtask

  task automatic t_mismatch();
    rd(P0); rd(P1); rd(15'h1234); rd(P2); rd(P3); rd(P4); rd(FS);
    chk("R6 foreign read", got, 3'b000);
    rd(P0); rd(P1); rd(P1); rd(P2); rd(P3); rd(P4); rd(FS);
    chk("R6 repeated read", got, 3'b000);
  endtask

  task automatic t_restart();
    rd(P0); rd(P1); rd(P0); rd(P1); rd(P2); rd(P3); rd(P4); rd(FS);
    chk("R7 restart on first key", got, 3'b100);
    rd(P0); rd(P0); rd(P1); rd(P2); rd(P3); rd(P4); rd(FR);
    chk("R7 doubled first key", got, 3'b010);
  endtask

  task automatic t_busy();
    rd(P0); rd(P1);
    @(negedge clk); busy = 1'b1;
    rd(P2);
    @(negedge clk); busy = 1'b0;
    rd(P3); rd(P4); rd(FS);
    chk("R8 event while busy", got, 3'b000);
    prefix();
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0;
    rd(FS);
    chk("R8 busy clears progress", got, 3'b000);
  endtask

  task automatic t_bit14();
    rd(P0 | 15'h4000); rd(P1 | 15'h4000); rd(P2 | 15'h4000);
    rd(P3 | 15'h4000); rd(P4 | 15'h4000); rd(FR | 15'h4000);
    chk("R9 bit 14 ignored", got, 3'b010);
  endtask

  task automatic t_bad_final();
    prefix(); rd(15'h1111);
    chk("R12 unknown final", got, 3'b000);
    prefix(); rd(FS);
    chk("R12 detection after unknown final", got, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_store();
    t_recall();
    t_test();
    t_order();
    t_write();
    t_mismatch();
    t_restart();
    t_busy();
    t_bit14();
    t_bad_final();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule